// File: doc/BRIEF.md
# Packed FP32 Horizontal Subtract Unit

This block is a four-lane binary32 datapath that takes two 128-bit vectors, a destination vector and a source vector, each holding four single-precision elements. Each lane forms the difference of two adjacent elements within one vector, not of matching elements across the two vectors. The low half of the result comes from the destination vector and the high half from the source vector. Each lane rounds to nearest, ties to even. The five numeric exception conditions are merged across the four lanes and returned with the result.

The source vector may come from memory. In that case the block also checks that the supplied byte address sits on a 16-byte boundary. A misaligned address produces a fault pulse in the slot where the result would have appeared, and no result is written.

The unit has a fixed latency of 13 cycles and accepts at most one operation every 4 cycles. It holds `in_ready` low during the gap, and an `in_valid` offered while `in_ready` is low is dropped.

Top module: `hdiff_unit`

## Requirements
- R1: Element i of a vector occupies bits 32i+31:32i. Result lane 0 is dst element 0 minus dst element 1, lane 1 is dst element 2 minus dst element 3, lane 2 is src element 0 minus src element 1, and lane 3 is src element 2 minus src element 3.
- R2: Each lane rounds its difference to nearest, ties to even. Any inexact lane sets the inexact flag.
- R3: A difference whose rounded magnitude exceeds the largest finite value becomes an infinity with the sign of the exact difference, and it sets both overflow and inexact. Infinity minus infinity of opposite signs gives that infinity with no flag.
- R4: A signalling NaN operand, or infinity minus infinity of the same sign, yields 0x7FC00000 and sets invalid. Otherwise a quiet NaN passes through unchanged, with the minuend taking precedence over the subtrahend, and invalid stays clear.
- R5: A subnormal operand sets the denormal flag and enters the arithmetic at full precision. Subnormal differences are exact, so underflow stays clear.
- R6: An exact zero difference is +0, except that (-0) minus (+0) is -0.
- R7: `out_flags` is the OR over the four lanes, with bit 4 invalid, bit 3 denormal, bit 2 overflow, bit 1 underflow and bit 0 inexact.
- R8: An operation accepted on a rising edge makes `out_valid` high for exactly one cycle following the 13th rising edge, counting the accepting edge. `out_valid` is low in the cycle before that.
- R9: After an acceptance `in_ready` is low for three cycles. An `in_valid` during that time is dropped and never produces an output.
- R10: When `src_mem` is 1 and the low four address bits are nonzero, the output slot carries `out_fault`=1 with `out_valid`=0, and data and flags are zero. When `src_mem` is 0 the address is ignored. `out_data` and `out_flags` are zero whenever `out_valid` is low.
- R11: During and right after reset, `in_ready` is 1, and `out_valid`, `out_fault` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept this cycle |
| dst_op | input | 128 | Destination vector, four binary32 elements |
| src_op | input | 128 | Source vector, four binary32 elements |
| src_mem | input | 1 | Source vector comes from memory |
| src_addr | input | ADDR_W | Byte address of the memory source |
| out_valid | output | 1 | Result valid pulse |
| out_data | output | 128 | Four differences |
| out_flags | output | 5 | Invalid, denormal, overflow, underflow, inexact |
| out_fault | output | 1 | Alignment fault pulse in place of a result |

## Verification
The bench aims at exact ties on both an even and an odd last place. A unit that always rounds half up would return 0x3F800001 where 1.0 is expected. It covers the sign of an exact zero, which a naive adder returns as +0 for (-0)-(+0). It covers same-sign infinity subtraction and signalling NaNs, where a careless design would pass an infinity or the raw NaN through without raising invalid, and it covers a quiet NaN whose payload must survive unchanged. It also checks subnormal differences that must come out exact, with the denormal flag set. On the control side it offers inputs during the issue gap, which a design without the gate would turn into extra results, and it checks that a misaligned memory source produces a fault pulse with no data while the same address is ignored when the source is a register.

// File: rtl/hdiff_pkg.sv
package hdiff_pkg;

    localparam int LANE_W = 32;
    localparam int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;

    localparam logic [LANE_W-1:0] QNAN_DFLT = 32'h7FC0_0000;

    // bit 4 .. bit 0
    typedef struct packed {
        logic inv;
        logic den;
        logic ovf;
        logic unf;
        logic inx;
    } hd_flags_t;

    typedef struct packed {
        logic             vld;
        logic             flt;
        logic [VEC_W-1:0] data;
        hd_flags_t        flags;
    } hd_stage_t;

    // leading zeros of a 27-bit significand window (27 when empty)
    function automatic logic [4:0] lzc27(input logic [26:0] v);
        logic [4:0] n;
        n = 5'd27;
        for (int i = 0; i < 27; i++) begin
            if (v[i]) n = 5'(26 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/hdiff_lane.sv
module hdiff_lane
    import hdiff_pkg::*;
(
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [LANE_W-1:0] res,
    output hd_flags_t         flg
);

    logic        sa, sbn;
    logic [7:0]  ea, eb;
    logic [22:0] fa, fb;
    logic        a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_den, b_den;

    assign sa  = a[31];
    assign sbn = ~b[31];
    assign ea  = a[30:23];
    assign eb  = b[30:23];
    assign fa  = a[22:0];
    assign fb  = b[22:0];

    assign a_nan  = (ea == 8'hFF) && (fa != '0);
    assign b_nan  = (eb == 8'hFF) && (fb != '0);
    assign a_snan = a_nan && !fa[22];
    assign b_snan = b_nan && !fb[22];
    assign a_inf  = (ea == 8'hFF) && (fa == '0);
    assign b_inf  = (eb == 8'hFF) && (fb == '0);
    assign a_den  = (ea == 8'h00) && (fa != '0);
    assign b_den  = (eb == 8'h00) && (fb != '0);

    logic        swap, s_big, s_small;
    logic [7:0]  e_big, e_small, dexp;
    logic [23:0] m_big, m_small;
    logic [27:0] big_x, small_x, small_sh, sum;
    logic        stk;
    logic [26:0] norm;
    logic [9:0]  e_n, e_room, sh;
    logic [4:0]  lz;
    logic        g_bit, r_bits, rup, inexact_f, tiny, ovf_f;
    logic [7:0]  exp_field;
    logic [30:0] packed_pre, packed_rnd;

    // finite magnitude path
    always_comb begin
        swap    = {eb, fb} > {ea, fa};
        s_big   = swap ? sbn : sa;
        s_small = swap ? sa  : sbn;
        e_big   = swap ? ((eb == 8'h00) ? 8'd1 : eb) : ((ea == 8'h00) ? 8'd1 : ea);
        e_small = swap ? ((ea == 8'h00) ? 8'd1 : ea) : ((eb == 8'h00) ? 8'd1 : eb);
        m_big   = swap ? {eb != 8'h00, fb} : {ea != 8'h00, fa};
        m_small = swap ? {ea != 8'h00, fa} : {eb != 8'h00, fb};
        dexp    = e_big - e_small;
        big_x   = {1'b0, m_big, 3'b000};
        small_x = {1'b0, m_small, 3'b000};

        if (dexp >= 8'd28) begin
            small_sh = '0;
            stk      = |small_x;
        end else begin
            small_sh = small_x >> dexp;
            stk      = |(small_x & ((28'd1 << dexp) - 28'd1));
        end
        small_sh[0] = small_sh[0] | stk;

        sum = (s_big == s_small) ? (big_x + small_sh) : (big_x - small_sh);

        e_n    = {2'b00, e_big};
        lz     = lzc27(sum[26:0]);
        e_room = e_n - 10'd1;
        sh     = '0;
        if (sum[27]) begin
            norm = {sum[27:2], sum[1] | sum[0]};
            e_n  = e_n + 10'd1;
        end else begin
            sh   = ({5'b0, lz} > e_room) ? e_room : {5'b0, lz};
            norm = sum[26:0] << sh;
            e_n  = e_n - sh;
        end

        g_bit      = norm[2];
        r_bits     = norm[1] | norm[0];
        rup        = g_bit & (r_bits | norm[3]);
        inexact_f  = g_bit | r_bits;
        tiny       = !norm[26];
        exp_field  = norm[26] ? e_n[7:0] : 8'h00;
        packed_pre = {exp_field, norm[25:3]};
        packed_rnd = packed_pre + {30'b0, rup};
        ovf_f      = (e_n >= 10'd255) || (packed_rnd[30:23] == 8'hFF);
    end

    // special-value selection
    always_comb begin
        res     = '0;
        flg     = '0;
        flg.den = a_den | b_den;
        if (a_snan || b_snan) begin
            res     = QNAN_DFLT;
            flg.inv = 1'b1;
        end else if (a_nan) begin
            res = a;
        end else if (b_nan) begin
            res = b;
        end else if (a_inf && b_inf) begin
            if (sa == sbn) begin
                res = {sa, 8'hFF, 23'b0};
            end else begin
                res     = QNAN_DFLT;
                flg.inv = 1'b1;
            end
        end else if (a_inf) begin
            res = a;
        end else if (b_inf) begin
            res = {sbn, 8'hFF, 23'b0};
        end else if (sum == '0) begin
            res = {sa & sbn, 31'b0};
        end else if (ovf_f) begin
            res     = {s_big, 8'hFF, 23'b0};
            flg.ovf = 1'b1;
            flg.inx = 1'b1;
        end else begin
            res     = {s_big, packed_rnd};
            flg.inx = inexact_f;
            flg.unf = tiny & inexact_f;
        end
    end

endmodule

// File: rtl/hdiff_issue.sv
module hdiff_issue #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    output logic accept
);

    localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;

    logic [CW-1:0] wait_cnt;

    assign in_ready = (wait_cnt == '0);
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt <= '0;
        end else if (accept) begin
            wait_cnt <= CW'(GAP - 1);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/hdiff_delay.sv
module hdiff_delay
    import hdiff_pkg::*;
#(
    parameter int DEPTH = 13
) (
    input  logic      clk,
    input  logic      rst,
    input  hd_stage_t d,
    output hd_stage_t q
);

    hd_stage_t pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[DEPTH-1];

endmodule

// File: rtl/hdiff_unit.sv
module hdiff_unit
    import hdiff_pkg::*;
#(
    parameter int LATENCY    = 13,
    parameter int ISSUE_GAP  = 4,
    parameter int ADDR_W     = 48,
    parameter int ALIGN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VEC_W-1:0]  dst_op,
    input  logic [VEC_W-1:0]  src_op,
    input  logic              src_mem,
    input  logic [ADDR_W-1:0] src_addr,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_data,
    output logic [4:0]        out_flags,
    output logic              out_fault
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_LOG2) - 1);

    logic       accept, misaligned;
    logic [VEC_W-1:0] diff_vec;
    hd_flags_t  lane_flg [LANES];
    hd_flags_t  merged;
    hd_stage_t  stage_in, stage_out;

    hdiff_issue #(.GAP(ISSUE_GAP)) u_issue (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .accept   (accept)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        localparam int BASE = (ln % 2) * 2 * LANE_W;
        logic [LANE_W-1:0] minu, subt;
        if (ln < LANES / 2) begin : g_dst
            assign minu = dst_op[BASE +: LANE_W];
            assign subt = dst_op[BASE + LANE_W +: LANE_W];
        end else begin : g_src
            assign minu = src_op[BASE +: LANE_W];
            assign subt = src_op[BASE + LANE_W +: LANE_W];
        end
        hdiff_lane u_lane (
            .a   (minu),
            .b   (subt),
            .res (diff_vec[ln*LANE_W +: LANE_W]),
            .flg (lane_flg[ln])
        );
    end

    always_comb begin
        merged = '0;
        for (int i = 0; i < LANES; i++) merged = merged | lane_flg[i];
    end

    assign misaligned = src_mem && ((src_addr & ALIGN_MASK) != '0);

    always_comb begin
        stage_in      = '0;
        stage_in.vld  = accept && !misaligned;
        stage_in.flt  = accept && misaligned;
        if (accept && !misaligned) begin
            stage_in.data  = diff_vec;
            stage_in.flags = merged;
        end
    end

    hdiff_delay #(.DEPTH(LATENCY)) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (stage_in),
        .q   (stage_out)
    );

    assign out_valid = stage_out.vld;
    assign out_fault = stage_out.flt;
    assign out_data  = stage_out.data;
    assign out_flags = stage_out.flags;

endmodule

// File: rtl/hdiff_chk.sv
module hdiff_chk #(
    parameter int ISSUE_GAP = 4
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_fault,
    input logic [127:0] out_data,
    input logic [4:0]   out_flags
);

    logic [7:0] pend;
    logic       took, done;

    assign took = in_valid && in_ready;
    assign done = out_valid || out_fault;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend + {7'b0, took} - {7'b0, done};
    end

    // R8: every output slot belongs to an earlier acceptance
    p_no_orphan_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (pend != 8'd0));

    // R10: fault and result never share a slot
    p_fault_excl_r10: assert property (@(posedge clk) disable iff (rst)
        out_fault |-> !out_valid);

    // R10: quiet outputs when no result is presented
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_data == '0 && out_flags == '0));

    if (ISSUE_GAP > 1) begin : g_gap
        // R9: ready drops right after an acceptance
        p_ready_gap_r9: assert property (@(posedge clk) disable iff (rst)
            took |=> !in_ready);

        // R8: output slots are single-cycle pulses
        p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
            done |=> !done);
    end

endmodule

bind hdiff_unit hdiff_chk #(.ISSUE_GAP(ISSUE_GAP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_fault (out_fault),
    .out_data  (out_data),
    .out_flags (out_flags)
);

// File: tb/tb_hdiff_unit.sv
`timescale 1ns/1ps
module tb_hdiff_unit;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] dst_op, src_op;
    logic         src_mem;
    logic [47:0]  src_addr;
    logic         out_valid;
    logic [127:0] out_data;
    logic [4:0]   out_flags;
    logic         out_fault;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    hdiff_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .dst_op(dst_op), .src_op(src_op), .src_mem(src_mem), .src_addr(src_addr),
        .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags),
        .out_fault(out_fault)
    );

    function automatic logic [127:0] v4(input logic [31:0] e0, e1, e2, e3);
        return {e3, e2, e1, e0};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // one operation through the full latency, checked at its slot
    task automatic run_op(input string req, input logic [127:0] d, input logic [127:0] s,
                          input logic mem, input logic [47:0] addr,
                          input logic [127:0] exp_data, input logic [4:0] exp_flags,
                          input logic exp_fault);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; dst_op = d; src_op = s; src_mem = mem; src_addr = addr;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (11) @(posedge clk);
        @(negedge clk);
        chk({req, " R8"}, "early slot", {126'b0, out_valid, out_fault}, '0);
        @(posedge clk);
        @(negedge clk);
        chk(req, "out_valid", {127'b0, out_valid}, {127'b0, !exp_fault});
        chk(req, "out_fault", {127'b0, out_fault}, {127'b0, exp_fault});
        chk(req, "out_data", out_data, exp_data);
        chk(req, "out_flags", {123'b0, out_flags}, {123'b0, exp_flags});
        @(posedge clk);
        @(negedge clk);
        chk({req, " R8"}, "pulse width", {126'b0, out_valid, out_fault}, '0);
    endtask

    // R1 lane mapping on exact values
    task automatic t_mapping();
        run_op("R1", v4(32'h40400000, 32'h3F800000, 32'h3F800000, 32'h40800000),
               v4(32'h41200000, 32'h40200000, 32'hBF800000, 32'h3F000000), 1'b0, 48'h0,
               v4(32'h40000000, 32'hC0400000, 32'h40F00000, 32'hBFC00000), 5'h00, 1'b0);
    endtask

    // R2 ties to even (even and odd last place) and an exact lane
    task automatic t_round();
        run_op("R2", v4(32'h3F800000, 32'hB3800000, 32'h3F800001, 32'hB3800000),
               v4(32'h3F800000, 32'h33000000, 32'h3FC00000, 32'h3F000000), 1'b0, 48'h0,
               v4(32'h3F800000, 32'h3F800002, 32'h3F800000, 32'h3F800000), 5'h01, 1'b0);
    endtask

    // R3 overflow both signs, opposite infinities; R6 exact zeros
    task automatic t_overflow();
        run_op("R3", v4(32'h7F7FFFFF, 32'hFF7FFFFF, 32'hFF7FFFFF, 32'h7F7FFFFF),
               v4(32'h40000000, 32'h40000000, 32'h7F800000, 32'hFF800000), 1'b0, 48'h0,
               v4(32'h7F800000, 32'hFF800000, 32'h00000000, 32'h7F800000), 5'h05, 1'b0);
    endtask

    // R4 signalling NaN, inf-inf, quiet NaN payloads with minuend first
    task automatic t_nan();
        run_op("R4", v4(32'h7F800001, 32'h3F800000, 32'h7F800000, 32'h7F800000),
               v4(32'h3F800000, 32'h7FC12345, 32'hFFC00077, 32'h7FC00001), 1'b0, 48'h0,
               v4(32'h7FC00000, 32'h7FC00000, 32'h7FC12345, 32'hFFC00077), 5'h10, 1'b0);
    endtask

    // R5 subnormal operands and results; R6 signed zero
    task automatic t_denorm_zero();
        run_op("R5 R6", v4(32'h00000003, 32'h00000001, 32'h00800000, 32'h00000001),
               v4(32'h80000000, 32'h00000000, 32'h40000000, 32'h40000000), 1'b0, 48'h0,
               v4(32'h00000002, 32'h007FFFFF, 32'h80000000, 32'h00000000), 5'h08, 1'b0);
    endtask

    // R7 flags from different lanes merge
    task automatic t_merge();
        run_op("R7", v4(32'h00000001, 32'h00000000, 32'h7F800001, 32'h00000000),
               v4(32'h40A00000, 32'h40A00000, 32'h3F800000, 32'hB3800000), 1'b0, 48'h0,
               v4(32'h00000001, 32'h7FC00000, 32'h00000000, 32'h3F800000), 5'h19, 1'b0);
    endtask

    // R10 alignment fault and ignored address
    task automatic t_align();
        logic [127:0] d, s, r;
        d = v4(32'h40400000, 32'h3F800000, 32'h3F800000, 32'h40800000);
        s = v4(32'h41200000, 32'h40200000, 32'hBF800000, 32'h3F000000);
        r = v4(32'h40000000, 32'hC0400000, 32'h40F00000, 32'hBFC00000);
        run_op("R10 misaligned", d, s, 1'b1, 48'h1008, '0, 5'h00, 1'b1);
        run_op("R10 aligned", d, s, 1'b1, 48'h2000, r, 5'h00, 1'b0);
        run_op("R10 register source", d, s, 1'b0, 48'h0007, r, 5'h00, 1'b0);
    endtask

    // R9 issue gap: refused input and back-to-back acceptance
    task automatic t_issue_gap();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; src_mem = 1'b0; src_addr = '0;
        dst_op = v4(32'h40400000, 32'h3F800000, 32'h3F800000, 32'h40800000);
        src_op = v4(32'h41200000, 32'h40200000, 32'hBF800000, 32'h3F000000);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "ready after accept", {127'b0, in_ready}, '0);
        dst_op = v4(32'h3F800000, 32'h3F800000, 32'h3F800000, 32'h3F800000);
        src_op = dst_op;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "ready gap 2", {127'b0, in_ready}, '0);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "ready gap 3", {127'b0, in_ready}, '0);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9", "ready back", {127'b0, in_ready}, 128'd1);
        in_valid = 1'b1;
        dst_op = v4(32'h3F800000, 32'hB3800000, 32'h3F800001, 32'hB3800000);
        src_op = v4(32'h3F800000, 32'h33000000, 32'h3FC00000, 32'h3F000000);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R9", "quiet before first", {127'b0, out_valid}, '0);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "first result", out_data,
            v4(32'h40000000, 32'hC0400000, 32'h40F00000, 32'hBFC00000));
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9", "refused input silent", {126'b0, out_valid, out_fault}, '0);
        end
        @(posedge clk);
        @(negedge clk);
        chk("R9", "second valid", {127'b0, out_valid}, 128'd1);
        chk("R9", "second result", out_data,
            v4(32'h3F800000, 32'h3F800002, 32'h3F800000, 32'h3F800000));
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R9", "no extra output", {126'b0, out_valid, out_fault}, '0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; dst_op = '0; src_op = '0;
        src_mem = 1'b0; src_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "in_ready", {127'b0, in_ready}, 128'd1);
        chk("R11", "out_valid", {127'b0, out_valid}, '0);
        chk("R11", "out_fault", {127'b0, out_fault}, '0);
        chk("R11", "out_data", out_data, '0);
        rst = 1'b0;
        t_mapping();
        t_round();
        t_overflow();
        t_nan();
        t_denorm_zero();
        t_merge();
        t_align();
        t_issue_gap();
        summary();
    end

endmodule